// File: doc/BRIEF.md
# Partitioned Bit-Serial FIR Filter with Serial Adder Tree

This block is a constant-coefficient FIR filter that works one bit per clock. Samples arrive on a single wire in two's complement, least significant bit first. The taps are split into NSUB groups of TAPS consecutive taps. Each group is a small distributed-arithmetic stage. It forms a table address from the current bit of every sample in its delay line, looks up the sum of the matching coefficients, and adds that sum into an accumulator, weighted by the bit position. The sign-bit cycle subtracts its term instead of adding it.

The delayed sample stream leaves each group on one wire and enters the next group, so the groups cover the taps in sequence. Each group quantizes its exact sum to a DW-bit word and sends it out serially, sign-extended. A tree of serial adders with clog2(NSUB) levels sums the group words into one serial result. Each adder is a full adder with a carry flip-flop. A frame lasts FL = DW + clog2(NSUB) cycles. A strobe marks bit 0 of every frame, and the result for a sample comes out during the frame after the one in which that sample arrived.

Top module: `dafir_top`

## Requirements
- R1: While rst_n is low and in the first frame after it is released, result_bit_o is 0 and no earlier sample has any effect. frame_start_o is 1 in the first cycle after release.
- R2: frame_start_o is 1 for exactly one cycle in every FL = DW + clog2(NSUB) cycles. The input sample bits are taken in frame cycles 0..DW-1, least significant bit first.
- R3: The value of sample_bit_i in frame cycles DW..FL-1 has no effect on any output.
- R4: Global tap t (0 ≤ t < NSUB·TAPS) has coefficient c(t) = ((29·t + 7) mod 61) − 30. Group g covers taps g·TAPS .. g·TAPS+TAPS−1, and tap t multiplies the sample received t frames earlier.
- R5: The word of group g is the low DW bits (two's complement wrap) of floor(S_g / 2^QSH), where S_g is the exact sum over the group's taps of c(t)·x. The sign bit of x carries weight −2^(DW−1).
- R6: The FL-bit word on result_bit_o, least significant bit first in frame m+1, is the exact signed sum of all group words for sample m.
- R7: In frame cycles DW..FL−1, each group's serial word repeats its sign bit.
- R8: No adder carry passes from one frame into the next.
- R9: A sample has no effect on outputs once NSUB·TAPS frames have passed after its own frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_bit_i | input | 1 | Serial input sample, LSB first |
| frame_start_o | output | 1 | High in cycle 0 of each frame |
| result_bit_o | output | 1 | Serial filter result, LSB first |

## Verification
A single impulse gives back the coefficient sequence, quantized per group. This shows whether the taps are in the right order and at the right group boundaries, and the zero tail after it shows that old samples are forgotten. A held most-negative step puts the subtracted sign term and the sign extension under full load, and a held positive step shows the matching positive path. Alternating extremes make the largest change in carries from one frame to the next, so any carry that leaks across a frame shows up. Pseudo-random samples with random junk in the tail cycles of each frame compare the whole datapath against a direct convolution computed in the bench, and a reset in the middle of a frame must clear the whole history.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // Constant coefficient of global tap t.
  function automatic int tap_coef(input int t);
    return ((t * 29 + 7) % 61) - 30;
  endfunction

  // Sum of the coefficients of the taps selected by addr within one group.
  function automatic int tap_group_sum(input int base, input int taps, input int addr);
    int s;
    s = 0;
    for (int j = 0; j < taps; j++) begin
      if (((addr >> j) & 1) != 0) s += tap_coef(base + j);
    end
    return s;
  endfunction

endpackage

// File: rtl/dafir_sadd.sv
module dafir_sadd (
  input  logic clk,
  input  logic rst_n,
  input  logic first_i,
  input  logic a_i,
  input  logic b_i,
  output logic s_o
);
  logic cy_q;
  logic cy_eff;

  assign cy_eff = first_i ? 1'b0 : cy_q;
  assign s_o    = a_i ^ b_i ^ cy_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cy_q <= 1'b0;
    else        cy_q <= (a_i & b_i) | (cy_eff & (a_i ^ b_i));
  end

  // R8
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_i |-> (s_o == (a_i ^ b_i)));
endmodule

// File: rtl/dafir_sub.sv
module dafir_sub #(
  parameter int DW   = 8,
  parameter int TAPS = 5,
  parameter int TBW  = 11,
  parameter int QSH  = 8,
  parameter int FL   = 10,
  parameter int CNTW = 4,
  parameter int BASE = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en_i,
  input  logic            first_i,
  input  logic            last_i,
  input  logic            load_i,
  input  logic [CNTW-1:0] bit_idx_i,
  input  logic            din_i,
  output logic            chain_o,
  output logic            leaf_o
);
  import dafir_pkg::*;

  localparam int ACCW = TBW + DW;
  localparam int NENT = 1 << TAPS;

  logic [DW-1:0]          tap_q [TAPS];
  logic [TAPS-1:0]        addr;
  logic signed [TBW-1:0]  lut [NENT];
  logic signed [ACCW-1:0] f_ext, weighted, acc_sum, acc_q;
  logic [DW-1:0]          word_new, res_q, word_sel;
  logic [FL-1:0]          out_sh;

  // Constant table of coefficient sums for this group.
  for (genvar a = 0; a < NENT; a++) begin : g_lut
    assign lut[a] = TBW'(tap_group_sum(BASE, TAPS, a));
  end

  assign addr[0] = din_i;
  for (genvar j = 1; j < TAPS; j++) begin : g_addr
    assign addr[j] = tap_q[j-1][0];
  end

  assign f_ext    = ACCW'(lut[addr]);
  assign weighted = f_ext <<< bit_idx_i;
  assign acc_sum  = (first_i ? '0 : acc_q) + (last_i ? -weighted : weighted);
  assign word_new = DW'(acc_sum >>> QSH);
  assign word_sel = last_i ? word_new : res_q;
  assign chain_o  = tap_q[TAPS-1][0];
  assign leaf_o   = out_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < TAPS; j++) tap_q[j] <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else if (shift_en_i) begin
      tap_q[0] <= {din_i, tap_q[0][DW-1:1]};
      for (int j = 1; j < TAPS; j++) tap_q[j] <= {tap_q[j-1][0], tap_q[j][DW-1:1]};
      acc_q <= acc_sum;
      if (last_i) res_q <= word_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_sh <= '0;
    else if (load_i) out_sh <= FL'($signed(word_sel));
    else             out_sh <= {out_sh[FL-1], out_sh[FL-1:1]};
  end

  if (FL > DW) begin : g_ext_chk
    // R7
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_idx_i >= CNTW'(DW)) |-> (leaf_o == $past(leaf_o)));
  end
endmodule

// File: rtl/dafir_top.sv
module dafir_top #(
  parameter int DW   = 8,
  parameter int NSUB = 4,
  parameter int TAPS = 5,
  parameter int CW   = 8,
  parameter int QSH  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_bit_i,
  output logic frame_start_o,
  output logic result_bit_o
);
  localparam int TREEB = $clog2(NSUB);
  localparam int FL    = DW + TREEB;
  localparam int CNTW  = $clog2(FL + 1);
  localparam int TBW   = CW + $clog2(TAPS) + 1;
  localparam int NLEAF = 1 << TREEB;

  logic [CNTW-1:0] cnt_q;
  logic            shift_en, first_bit, last_bit, load_out;
  logic [NSUB:0]   chain;
  logic [NSUB-1:0] leaf;
  logic            node [2*NLEAF-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (cnt_q == CNTW'(FL - 1))   cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  assign shift_en      = cnt_q < CNTW'(DW);
  assign first_bit     = cnt_q == '0;
  assign last_bit      = cnt_q == CNTW'(DW - 1);
  assign load_out      = cnt_q == CNTW'(FL - 1);
  assign frame_start_o = first_bit;
  assign chain[0]      = sample_bit_i;

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    dafir_sub #(.DW(DW), .TAPS(TAPS), .TBW(TBW), .QSH(QSH), .FL(FL),
                .CNTW(CNTW), .BASE(g * TAPS)) u_sub (
      .clk(clk), .rst_n(rst_n), .shift_en_i(shift_en), .first_i(first_bit),
      .last_i(last_bit), .load_i(load_out), .bit_idx_i(cnt_q),
      .din_i(chain[g]), .chain_o(chain[g+1]), .leaf_o(leaf[g]));
  end

  for (genvar k = 0; k < NLEAF; k++) begin : g_leaf
    if (k < NSUB) begin : g_used
      assign node[NLEAF-1+k] = leaf[k];
    end else begin : g_pad
      assign node[NLEAF-1+k] = 1'b0;
    end
  end

  for (genvar n = 0; n < NLEAF - 1; n++) begin : g_tree
    dafir_sadd u_add (.clk(clk), .rst_n(rst_n), .first_i(first_bit),
                      .a_i(node[2*n+1]), .b_i(node[2*n+2]), .s_o(node[n]));
  end

  assign result_bit_o = node[0];

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);
  // R2
  strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNTW'(FL - 1)) |=> frame_start_o);
  // R3
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain[NSUB:1]));
endmodule

// File: tb/dafir_top_tb_top.sv
`timescale 1ns/1ps
module dafir_top_tb_top;
  localparam int DW = 8, NSUB = 4, TAPS = 5, QSH = 8;
  localparam int FL = DW + 2;
  localparam int NT = NSUB * TAPS;
  localparam int NSEG = 15;
  // stimulus segments: value, repeat count
  localparam int SEG_VAL [NSEG] = '{100, 0, 0, -128, 127, -128, 127, -128, 127,
                                    -128, 127, -128, 127, 0, 0};
  localparam int SEG_CNT [NSEG] = '{1, 19, 3, 22, 22, 1, 1, 1, 1, 1, 1, 1, 1, 20, 3};

  logic clk = 1'b0, rst_n = 1'b0, sample_bit_i = 1'b0;
  logic frame_start_o, result_bit_o;
  int total = 0, bad = 0;
  int hist [NT];
  int exp_prev = 0;
  string tag_prev = "R1 first frame";
  logic [31:0] st = 32'h1234_5678;

  always #2.5 clk = ~clk;

  dafir_top dut_i (.clk(clk), .rst_n(rst_n), .sample_bit_i(sample_bit_i),
                   .frame_start_o(frame_start_o), .result_bit_o(result_bit_o));

  function automatic string seg_tag(input int s);
    case (s)
      0, 1:    return "R4 R5 R6 impulse";
      2:       return "R9 impulse tail";
      3:       return "R5 R7 negative step";
      4:       return "R6 positive step";
      13, 14:  return "R9 R8 settle";
      default: return "R8 alternating";
    endcase
  endfunction

  function automatic int coef(input int t);
    return ((7 + 29 * t) % 61) - 30;
  endfunction

  // Direct convolution, quantized per group as the requirements describe.
  function automatic int ref_out();
    int y, s, q;
    y = 0;
    for (int g = 0; g < NSUB; g++) begin
      s = 0;
      for (int j = 0; j < TAPS; j++) s += coef(g * TAPS + j) * hist[g * TAPS + j];
      q = s >>> QSH;
      q = q & ((1 << DW) - 1);
      if (q >= (1 << (DW - 1))) q -= (1 << DW);
      y += q;
    end
    return y;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < NT; i++) hist[i] = 0;
    exp_prev = 0;
  endtask

  // One frame: collect the previous result, feed sample xv (tail bits from tail).
  task automatic run_frame(input int xv, input logic [FL-1:0] tail, input string tag);
    logic [FL-1:0] got;
    logic [DW-1:0] xb;
    int strobe_err;
    xb = DW'(xv);
    strobe_err = 0;
    for (int b = 0; b < FL; b++) begin
      got[b] = result_bit_o;
      if (frame_start_o !== (b == 0)) strobe_err++;
      sample_bit_i = (b < DW) ? xb[b] : tail[b];
      @(negedge clk);
    end
    check(strobe_err == 0, "R2 strobe", strobe_err, 0);
    check(int'($signed(got)) == exp_prev, tag_prev, int'($signed(got)), exp_prev);
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = xv;
    exp_prev = ref_out();
    tag_prev = tag;
  endtask

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    return v ^ (v << 5);
  endfunction

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    // R1 state during reset
    check(result_bit_o == 1'b0, "R1 output in reset", int'(result_bit_o), 0);
    rst_n = 1'b1;
    // R1 strobe in first cycle after release
    check(frame_start_o == 1'b1, "R1 first strobe", int'(frame_start_o), 1);
    for (int s = 0; s < NSEG; s++) begin
      for (int r = 0; r < SEG_CNT[s]; r++) begin
        st = rnd(st);
        run_frame(SEG_VAL[s], FL'(st[15:0]), seg_tag(s));
      end
    end
    // R3 R5 R6 random samples with junk in the tail cycles
    for (int r = 0; r < 60; r++) begin
      st = rnd(st);
      run_frame(int'($signed(st[7:0])), FL'(st[31:16]), "R3 R5 R6 random");
    end
    // R1 reset in mid-frame clears the history
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    sample_bit_i = 1'b1;
    repeat (2) @(negedge clk);
    check(result_bit_o == 1'b0, "R1 output in reset", int'(result_bit_o), 0);
    rst_n = 1'b1;
    clear_hist();
    tag_prev = "R1 after reset";
    for (int r = 0; r < 4; r++) run_frame(0, '1, "R1 after reset");
    run_frame(-1, '0, "R5 minus one");
    run_frame(0, '0, "R5 minus one");
    run_frame(0, '0, "R5 minus one");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule